// File: doc/BRIEF.md
# Wear-Leveling Block Allocator

This block tracks the wear of a small pool of flash erase blocks and decides which physical block takes the next host write. Each table entry holds a saturating erase count, an in-use flag and a bad flag. An allocation request scans the whole table, one entry per clock. It returns the free, healthy block that has been erased the fewest times. If no such block exists, it reports a failure instead of an index. When a block is erased, its count goes up by one and the block returns to the free pool. A separate request marks a block bad, which takes it out of every later choice.

A sweep request, honoured only while the block is idle, runs the static policy. It finds the least-worn block that holds data and the most-worn healthy free block. If the free block's count is greater than the data block's count plus a threshold given with the request, it emits one relocation command that names both blocks. It then exchanges their in-use flags, so the cold data moves onto the worn block and the lightly used block rejoins the pool. The data copy itself and the logical-to-physical map belong to the surrounding firmware and datapath.

After reset the block spends one cycle per entry clearing the table and holds `busy` high. Requests are taken only while `busy` is low.

Top module: `wl_alloc`

## Requirements
- R1: After reset, `busy` is high while the table is cleared, and every entry then reads as free, healthy and with a count of zero. The first allocations therefore return indices 0, 1, 2 and so on.
- R2: An allocation returns, with `alloc_done` high and `alloc_fail` low, the index of the free, non-bad block with the smallest erase count.
- R3: When several candidates share the best erase count, the lowest index wins. This holds for allocation, for the sweep's data source and for the sweep's free destination.
- R4: A block handed out by an allocation is marked in use and is not returned again until it is erased.
- R5: An allocation when no free, non-bad block exists completes with `alloc_done` and `alloc_fail` both high.
- R6: An erase request increments the block's count by one and marks it free. The bad flag is left unchanged.
- R7: Erase counts saturate at the all-ones value of `CNT_W` bits and do not wrap.
- R8: A block marked bad is never chosen by allocation, nor as either side of a relocation.
- R9: A sweep fires when the most-worn free block's count is strictly greater than the least-worn data block's count plus `sweep_thr`. `chk_done` and `reloc_valid` are then high together for one cycle, with `reloc_src` set to the data block and `reloc_dst` set to the free block.
- R10: A sweep that does not meet the R9 condition, including the case of exact equality, completes with `chk_done` high and `reloc_valid` low, and it changes nothing.
- R11: After a relocation, the source block is free and the destination block is in use. Neither count changes.
- R12: Requests made while `busy` is high are dropped and have no effect.
- R13: Requests in the same idle cycle are ranked allocation, then erase, then mark-bad, then sweep. Only the highest-ranked request is served; the others are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_req | input | 1 | Pulse: allocate a block for a host write |
| erase_req | input | 1 | Pulse: block `erase_idx` has been erased |
| erase_idx | input | $clog2(N_BLK) | Block that was erased |
| mark_req | input | 1 | Pulse: retire block `mark_idx` as bad |
| mark_idx | input | $clog2(N_BLK) | Block to retire |
| sweep_req | input | 1 | Pulse: run the static wear check |
| sweep_thr | input | CNT_W | Wear gap that must be exceeded before a relocation fires |
| busy | output | 1 | High while clearing, scanning or updating; requests are dropped |
| alloc_done | output | 1 | One-cycle pulse: allocation result is valid |
| alloc_fail | output | 1 | With `alloc_done`: no candidate block existed |
| alloc_idx | output | $clog2(N_BLK) | With `alloc_done`: chosen block |
| chk_done | output | 1 | One-cycle pulse: sweep finished |
| reloc_valid | output | 1 | With `chk_done`: a relocation is commanded |
| reloc_src | output | $clog2(N_BLK) | Cold data block to move out |
| reloc_dst | output | $clog2(N_BLK) | Worn free block that receives the data |

## Verification
The bench is aimed at ties between equal counts, the count ceiling, bad blocks that would otherwise win, and a wear gap exactly equal to the threshold. A design that resolved ties by the last index seen, or that wrapped a count, would hand out or relocate the wrong block. Letting bad blocks through would make a sweep fire against a retired free block. Using greater-or-equal would emit a relocation at equality. Requests placed during a scan, and several requests raised in the same idle cycle, are checked through later allocations. A design that accepted them would free blocks that the model still holds in use, and a following allocation would return a block where a failure is due.

// File: rtl/wl_pkg.sv
package wl_pkg;

  typedef enum logic [2:0] {
    ST_INIT,
    ST_IDLE,
    ST_RMW,
    ST_ASCAN,
    ST_AFIN,
    ST_SSCAN,
    ST_SFIN,
    ST_SW2
  } wl_state_e;

endpackage

// File: rtl/wl_table.sv
// Simple dual-port table: one synchronous read port, one write port.
module wl_table #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 18,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/wl_pick.sv
// Running best-candidate tracker; strict compare keeps the earliest index on ties.
module wl_pick #(
  parameter int CNT_W    = 16,
  parameter int IDX_W    = 4,
  parameter bit WANT_MAX = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             vld,
  input  logic             cand,
  input  logic [IDX_W-1:0] idx,
  input  logic [CNT_W-1:0] cnt,
  output logic             ok,
  output logic [IDX_W-1:0] best_idx,
  output logic [CNT_W-1:0] best_cnt
);

  logic better;

  generate
    if (WANT_MAX) begin : g_max
      assign better = cnt > best_cnt;
    end else begin : g_min
      assign better = cnt < best_cnt;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      ok       <= 1'b0;
      best_idx <= '0;
      best_cnt <= '0;
    end else if (vld && cand && (!ok || better)) begin
      ok       <= 1'b1;
      best_idx <= idx;
      best_cnt <= cnt;
    end
  end

endmodule

// File: rtl/wl_ctrl.sv
module wl_ctrl
  import wl_pkg::*;
#(
  parameter int N_BLK = 16,
  parameter int CNT_W = 16,
  localparam int IDX_W = $clog2(N_BLK),
  localparam int ENT_W = CNT_W + 2,
  localparam int PTR_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc_req,
  input  logic             erase_req,
  input  logic [IDX_W-1:0] erase_idx,
  input  logic             mark_req,
  input  logic [IDX_W-1:0] mark_idx,
  input  logic             sweep_req,
  input  logic [CNT_W-1:0] sweep_thr,
  // table port
  output logic             t_we,
  output logic [IDX_W-1:0] t_waddr,
  output logic [ENT_W-1:0] t_wdata,
  output logic [IDX_W-1:0] t_raddr,
  input  logic [ENT_W-1:0] t_rdata,
  // scan feed
  output logic             s_clr,
  output logic             s_vld,
  output logic [IDX_W-1:0] s_idx,
  input  logic             fmin_ok,
  input  logic [IDX_W-1:0] fmin_idx,
  input  logic [CNT_W-1:0] fmin_cnt,
  input  logic             fmax_ok,
  input  logic [IDX_W-1:0] fmax_idx,
  input  logic [CNT_W-1:0] fmax_cnt,
  input  logic             dmin_ok,
  input  logic [IDX_W-1:0] dmin_idx,
  input  logic [CNT_W-1:0] dmin_cnt,
  // results
  output logic             busy,
  output logic             alloc_done,
  output logic             alloc_fail,
  output logic [IDX_W-1:0] alloc_idx,
  output logic             chk_done,
  output logic             reloc_valid,
  output logic [IDX_W-1:0] reloc_src,
  output logic [IDX_W-1:0] reloc_dst
);

  localparam int USED_B = CNT_W;
  localparam int BAD_B  = CNT_W + 1;
  localparam logic [PTR_W-1:0] PTR_END  = PTR_W'(N_BLK);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(N_BLK - 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;

  wl_state_e        state_q;
  logic [PTR_W-1:0] ptr_q;
  logic             op_mark_q;
  logic [IDX_W-1:0] op_idx_q;
  logic [CNT_W-1:0] thr_q;

  logic [CNT_W-1:0] old_cnt;
  logic [CNT_W-1:0] inc_cnt;
  logic             fire;

  assign old_cnt = t_rdata[CNT_W-1:0];
  assign inc_cnt = (old_cnt == CNT_MAX) ? old_cnt : old_cnt + 1'b1;
  assign fire    = fmax_ok && dmin_ok &&
                   ({1'b0, fmax_cnt} > ({1'b0, dmin_cnt} + {1'b0, thr_q}));

  assign busy  = (state_q != ST_IDLE);
  assign s_clr = (state_q == ST_IDLE);
  assign s_vld = ((state_q == ST_ASCAN) || (state_q == ST_SSCAN)) && (ptr_q != '0);
  assign s_idx = IDX_W'(ptr_q - PTR_W'(1));

  always_comb begin
    if (state_q == ST_IDLE) t_raddr = erase_req ? erase_idx : mark_idx;
    else                    t_raddr = ptr_q[IDX_W-1:0];
  end

  always_comb begin
    t_we    = 1'b0;
    t_waddr = '0;
    t_wdata = '0;
    unique case (state_q)
      ST_INIT: begin
        t_we    = 1'b1;
        t_waddr = ptr_q[IDX_W-1:0];
      end
      ST_RMW: begin
        t_we    = 1'b1;
        t_waddr = op_idx_q;
        if (op_mark_q) t_wdata = {1'b1, t_rdata[USED_B], old_cnt};
        else           t_wdata = {t_rdata[BAD_B], 1'b0, inc_cnt};
      end
      ST_AFIN: begin
        t_we    = fmin_ok;
        t_waddr = fmin_idx;
        t_wdata = {1'b0, 1'b1, fmin_cnt};
      end
      ST_SFIN: begin
        t_we    = fire;
        t_waddr = dmin_idx;
        t_wdata = {1'b0, 1'b0, dmin_cnt};
      end
      ST_SW2: begin
        t_we    = 1'b1;
        t_waddr = fmax_idx;
        t_wdata = {1'b0, 1'b1, fmax_cnt};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_INIT;
      ptr_q       <= '0;
      op_mark_q   <= 1'b0;
      op_idx_q    <= '0;
      thr_q       <= '0;
      alloc_done  <= 1'b0;
      alloc_fail  <= 1'b0;
      alloc_idx   <= '0;
      chk_done    <= 1'b0;
      reloc_valid <= 1'b0;
      reloc_src   <= '0;
      reloc_dst   <= '0;
    end else begin
      alloc_done  <= 1'b0;
      alloc_fail  <= 1'b0;
      chk_done    <= 1'b0;
      reloc_valid <= 1'b0;
      unique case (state_q)
        ST_INIT: begin
          if (ptr_q == PTR_LAST) begin
            ptr_q   <= '0;
            state_q <= ST_IDLE;
          end else begin
            ptr_q <= ptr_q + 1'b1;
          end
        end
        ST_IDLE: begin
          ptr_q <= '0;
          if (alloc_req) begin
            state_q <= ST_ASCAN;
          end else if (erase_req) begin
            op_mark_q <= 1'b0;
            op_idx_q  <= erase_idx;
            state_q   <= ST_RMW;
          end else if (mark_req) begin
            op_mark_q <= 1'b1;
            op_idx_q  <= mark_idx;
            state_q   <= ST_RMW;
          end else if (sweep_req) begin
            thr_q   <= sweep_thr;
            state_q <= ST_SSCAN;
          end
        end
        ST_RMW: state_q <= ST_IDLE;
        ST_ASCAN: begin
          ptr_q <= ptr_q + 1'b1;
          if (ptr_q == PTR_END) state_q <= ST_AFIN;
        end
        ST_AFIN: begin
          alloc_done <= 1'b1;
          alloc_fail <= !fmin_ok;
          alloc_idx  <= fmin_ok ? fmin_idx : '0;
          state_q    <= ST_IDLE;
        end
        ST_SSCAN: begin
          ptr_q <= ptr_q + 1'b1;
          if (ptr_q == PTR_END) state_q <= ST_SFIN;
        end
        ST_SFIN: begin
          chk_done    <= 1'b1;
          reloc_valid <= fire;
          reloc_src   <= fire ? dmin_idx : '0;
          reloc_dst   <= fire ? fmax_idx : '0;
          state_q     <= fire ? ST_SW2 : ST_IDLE;
        end
        ST_SW2: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/wl_alloc.sv
module wl_alloc #(
  parameter int N_BLK = 16,
  parameter int CNT_W = 16,
  localparam int IDX_W = $clog2(N_BLK),
  localparam int ENT_W = CNT_W + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc_req,
  input  logic             erase_req,
  input  logic [IDX_W-1:0] erase_idx,
  input  logic             mark_req,
  input  logic [IDX_W-1:0] mark_idx,
  input  logic             sweep_req,
  input  logic [CNT_W-1:0] sweep_thr,
  output logic             busy,
  output logic             alloc_done,
  output logic             alloc_fail,
  output logic [IDX_W-1:0] alloc_idx,
  output logic             chk_done,
  output logic             reloc_valid,
  output logic [IDX_W-1:0] reloc_src,
  output logic [IDX_W-1:0] reloc_dst
);

  localparam int USED_B = CNT_W;
  localparam int BAD_B  = CNT_W + 1;

  logic             t_we;
  logic [IDX_W-1:0] t_waddr;
  logic [ENT_W-1:0] t_wdata;
  logic [IDX_W-1:0] t_raddr;
  logic [ENT_W-1:0] t_rdata;

  logic             s_clr;
  logic             s_vld;
  logic [IDX_W-1:0] s_idx;
  logic             is_free;
  logic             is_data;

  logic             fmin_ok, fmax_ok, dmin_ok;
  logic [IDX_W-1:0] fmin_idx, fmax_idx, dmin_idx;
  logic [CNT_W-1:0] fmin_cnt, fmax_cnt, dmin_cnt;

  assign is_free = !t_rdata[BAD_B] && !t_rdata[USED_B];
  assign is_data = !t_rdata[BAD_B] &&  t_rdata[USED_B];

  wl_table #(.DEPTH(N_BLK), .WIDTH(ENT_W)) u_table (
    .clk   (clk),
    .we    (t_we),
    .waddr (t_waddr),
    .wdata (t_wdata),
    .raddr (t_raddr),
    .rdata (t_rdata)
  );

  wl_pick #(.CNT_W(CNT_W), .IDX_W(IDX_W), .WANT_MAX(1'b0)) u_free_min (
    .clk (clk), .rst (rst), .clr (s_clr), .vld (s_vld), .cand (is_free),
    .idx (s_idx), .cnt (t_rdata[CNT_W-1:0]),
    .ok (fmin_ok), .best_idx (fmin_idx), .best_cnt (fmin_cnt)
  );

  wl_pick #(.CNT_W(CNT_W), .IDX_W(IDX_W), .WANT_MAX(1'b1)) u_free_max (
    .clk (clk), .rst (rst), .clr (s_clr), .vld (s_vld), .cand (is_free),
    .idx (s_idx), .cnt (t_rdata[CNT_W-1:0]),
    .ok (fmax_ok), .best_idx (fmax_idx), .best_cnt (fmax_cnt)
  );

  wl_pick #(.CNT_W(CNT_W), .IDX_W(IDX_W), .WANT_MAX(1'b0)) u_data_min (
    .clk (clk), .rst (rst), .clr (s_clr), .vld (s_vld), .cand (is_data),
    .idx (s_idx), .cnt (t_rdata[CNT_W-1:0]),
    .ok (dmin_ok), .best_idx (dmin_idx), .best_cnt (dmin_cnt)
  );

  wl_ctrl #(.N_BLK(N_BLK), .CNT_W(CNT_W)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .alloc_req   (alloc_req),
    .erase_req   (erase_req),
    .erase_idx   (erase_idx),
    .mark_req    (mark_req),
    .mark_idx    (mark_idx),
    .sweep_req   (sweep_req),
    .sweep_thr   (sweep_thr),
    .t_we        (t_we),
    .t_waddr     (t_waddr),
    .t_wdata     (t_wdata),
    .t_raddr     (t_raddr),
    .t_rdata     (t_rdata),
    .s_clr       (s_clr),
    .s_vld       (s_vld),
    .s_idx       (s_idx),
    .fmin_ok     (fmin_ok),
    .fmin_idx    (fmin_idx),
    .fmin_cnt    (fmin_cnt),
    .fmax_ok     (fmax_ok),
    .fmax_idx    (fmax_idx),
    .fmax_cnt    (fmax_cnt),
    .dmin_ok     (dmin_ok),
    .dmin_idx    (dmin_idx),
    .dmin_cnt    (dmin_cnt),
    .busy        (busy),
    .alloc_done  (alloc_done),
    .alloc_fail  (alloc_fail),
    .alloc_idx   (alloc_idx),
    .chk_done    (chk_done),
    .reloc_valid (reloc_valid),
    .reloc_src   (reloc_src),
    .reloc_dst   (reloc_dst)
  );

endmodule

// File: rtl/wl_alloc_chk.sv
module wl_alloc_chk #(
  parameter int N_BLK = 16,
  parameter int CNT_W = 16,
  localparam int IDX_W = $clog2(N_BLK)
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             alloc_done,
  input logic             alloc_fail,
  input logic             chk_done,
  input logic             reloc_valid,
  input logic [IDX_W-1:0] reloc_src,
  input logic [IDX_W-1:0] reloc_dst
);

  // R1: table clearing follows every reset
  a_r1_busy_after_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> busy);

  // R5: failure flag only accompanies a completed allocation
  a_r5_fail_with_done: assert property (@(posedge clk) disable iff (rst)
    alloc_fail |-> alloc_done);

  // R9: relocation command only at sweep completion
  a_r9_reloc_with_done: assert property (@(posedge clk) disable iff (rst)
    reloc_valid |-> chk_done);

  // R11: a relocation pairs two different blocks
  a_r11_distinct_pair: assert property (@(posedge clk) disable iff (rst)
    reloc_valid |-> (reloc_src != reloc_dst));

  // R12: allocation result is a single pulse and the block is ready again
  a_r12_alloc_pulse: assert property (@(posedge clk) disable iff (rst)
    alloc_done |=> !alloc_done);

  a_r12_idle_at_result: assert property (@(posedge clk) disable iff (rst)
    alloc_done |-> !busy);

endmodule

bind wl_alloc wl_alloc_chk #(.N_BLK(N_BLK), .CNT_W(CNT_W)) u_wl_alloc_chk (
  .clk         (clk),
  .rst         (rst),
  .busy        (busy),
  .alloc_done  (alloc_done),
  .alloc_fail  (alloc_fail),
  .chk_done    (chk_done),
  .reloc_valid (reloc_valid),
  .reloc_src   (reloc_src),
  .reloc_dst   (reloc_dst)
);

// File: tb/wl_alloc_test.sv
module wl_alloc_test;

  localparam int N   = 16;
  localparam int CW  = 4;
  localparam int IW  = $clog2(N);
  localparam int CMX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          alloc_req = 1'b0;
  logic          erase_req = 1'b0;
  logic [IW-1:0] erase_idx = '0;
  logic          mark_req = 1'b0;
  logic [IW-1:0] mark_idx = '0;
  logic          sweep_req = 1'b0;
  logic [CW-1:0] sweep_thr = '0;
  logic          busy, alloc_done, alloc_fail, chk_done, reloc_valid;
  logic [IW-1:0] alloc_idx, reloc_src, reloc_dst;

  always #10 clk = ~clk;

  wl_alloc #(.N_BLK(N), .CNT_W(CW)) uut (
    .clk (clk), .rst (rst),
    .alloc_req (alloc_req), .erase_req (erase_req), .erase_idx (erase_idx),
    .mark_req (mark_req), .mark_idx (mark_idx),
    .sweep_req (sweep_req), .sweep_thr (sweep_thr),
    .busy (busy), .alloc_done (alloc_done), .alloc_fail (alloc_fail),
    .alloc_idx (alloc_idx), .chk_done (chk_done), .reloc_valid (reloc_valid),
    .reloc_src (reloc_src), .reloc_dst (reloc_dst)
  );

  int n_chk  = 0;
  int n_fail = 0;
  bit ended  = 0;

  typedef struct {
    bit is_alloc;
    bit fail;
    int idx;
    bit valid;
    int src;
    int dst;
    int req;
  } exp_t;

  exp_t exp_q[$];

  int m_cnt  [N];
  bit m_used [N];
  bit m_bad  [N];

  task automatic check(input bit ok, input int req, input string what,
                       input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL R%0d %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // ---------------- reference model ----------------
  function automatic void model_alloc(input int req);
    exp_t e;
    int best = -1;
    for (int i = 0; i < N; i++)
      if (!m_used[i] && !m_bad[i] && (best < 0 || m_cnt[i] < m_cnt[best])) best = i;
    e = '{1'b1, (best < 0), (best < 0) ? 0 : best, 1'b0, 0, 0, req};
    if (best >= 0) m_used[best] = 1'b1;
    exp_q.push_back(e);
  endfunction

  function automatic void model_sweep(input int thr, input int req);
    exp_t e;
    int d = -1;
    int f = -1;
    bit fire;
    for (int i = 0; i < N; i++) begin
      if (m_used[i] && !m_bad[i] && (d < 0 || m_cnt[i] < m_cnt[d])) d = i;
      if (!m_used[i] && !m_bad[i] && (f < 0 || m_cnt[i] > m_cnt[f])) f = i;
    end
    fire = (d >= 0) && (f >= 0) && (m_cnt[f] > m_cnt[d] + thr);
    e = '{1'b0, 1'b0, 0, fire, fire ? d : 0, fire ? f : 0, req};
    if (fire) begin
      m_used[d] = 1'b0;
      m_used[f] = 1'b1;
    end
    exp_q.push_back(e);
  endfunction

  function automatic void model_erase(input int i);
    if (m_cnt[i] < CMX) m_cnt[i]++;
    m_used[i] = 1'b0;
  endfunction

  // ---------------- driver tasks (entered at a negedge, block idle) -------
  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic do_alloc(input int req);
    model_alloc(req);
    alloc_req = 1'b1;
    wait_idle();
  endtask

  task automatic do_erase(input int i);
    model_erase(i);
    erase_idx = IW'(i);
    erase_req = 1'b1;
    @(negedge clk);
    erase_req = 1'b0;
    while (busy) @(negedge clk);
  endtask

  task automatic do_mark(input int i);
    m_bad[i] = 1'b1;
    mark_idx = IW'(i);
    mark_req = 1'b1;
    @(negedge clk);
    mark_req = 1'b0;
    while (busy) @(negedge clk);
  endtask

  task automatic do_sweep(input int thr, input int req);
    model_sweep(thr, req);
    sweep_thr = CW'(thr);
    sweep_req = 1'b1;
    @(negedge clk);
    sweep_req = 1'b0;
    while (busy) @(negedge clk);
  endtask

  // alloc_req is dropped on the first negedge inside wait_idle
  always @(negedge clk) if (alloc_req && busy) alloc_req = 1'b0;

  // ---------------- monitor / scoreboard ----------------
  always @(negedge clk) begin
    if (!rst && (alloc_done || chk_done || reloc_valid)) begin
      if (exp_q.size() == 0) begin
        check(1'b0, 0, "result with nothing expected", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (e.is_alloc) begin
          check(alloc_done && !chk_done, e.req, "alloc_done", int'(alloc_done), 1);
          check(alloc_fail == e.fail, e.req, "alloc_fail", int'(alloc_fail), int'(e.fail));
          if (!e.fail)
            check(int'(alloc_idx) == e.idx, e.req, "alloc_idx", int'(alloc_idx), e.idx);
        end else begin
          check(chk_done && !alloc_done, e.req, "chk_done", int'(chk_done), 1);
          check(reloc_valid == e.valid, e.req, "reloc_valid", int'(reloc_valid), int'(e.valid));
          if (e.valid) begin
            check(int'(reloc_src) == e.src, e.req, "reloc_src", int'(reloc_src), e.src);
            check(int'(reloc_dst) == e.dst, e.req, "reloc_dst", int'(reloc_dst), e.dst);
          end
        end
      end
    end
  end

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      n_chk++;
      n_fail++;
      $display("FAIL R0 watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    int waited;
    for (int i = 0; i < N; i++) begin
      m_cnt[i] = 0; m_used[i] = 0; m_bad[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: clearing in progress, no results
    check(busy == 1'b1, 1, "busy after reset", int'(busy), 1);
    check(!alloc_done && !reloc_valid, 1, "quiet after reset",
          int'(alloc_done | reloc_valid), 0);
    waited = 0;
    while (busy && waited < 4 * N) begin
      @(negedge clk);
      waited++;
    end
    check(waited <= N + 1, 1, "clear cycles", waited, N);

    // R1 R3 R4: fresh table hands out 0..N-1 in order
    for (int i = 0; i < N; i++) do_alloc(4);
    // R5 with R12: erase pulsed while busy must be dropped
    model_alloc(5);
    alloc_req = 1'b1;
    @(negedge clk);
    erase_idx = IW'(4);
    erase_req = 1'b1;
    mark_req  = 1'b1;
    mark_idx  = IW'(2);
    @(negedge clk);
    erase_req = 1'b0;
    mark_req  = 1'b0;
    while (busy) @(negedge clk);
    do_alloc(12);                 // R12: block 4 still in use -> fail
    // R13: alloc wins over a same-cycle erase, the erase is dropped
    model_alloc(13);
    erase_idx = IW'(6);
    erase_req = 1'b1;
    alloc_req = 1'b1;
    @(negedge clk);
    erase_req = 1'b0;
    while (busy) @(negedge clk);
    do_alloc(13);                 // R13: block 6 was not freed -> fail

    // R2 R3 R6: different wear, ties at count 1 between 3 and 9
    repeat (3) do_erase(5);
    do_erase(3);
    do_erase(9);
    repeat (2) do_erase(12);
    do_alloc(3);                  // R3 -> 3
    do_alloc(2);                  // R2 -> 9
    do_alloc(2);                  // R2 -> 12
    do_alloc(6);                  // R6 -> 5
    do_alloc(5);                  // R5 -> fail

    // R8: bad block ignored even though freed
    do_mark(5);
    do_erase(5);
    do_erase(7);
    do_alloc(8);                  // R8 -> 7
    do_alloc(8);                  // R8 -> fail
    do_sweep(0, 8);               // R8 R10: only free block is bad -> no fire

    // R7: saturating count makes a high-threshold sweep fire
    repeat (20) do_erase(2);
    do_sweep(14, 7);              // R7 R9: src 0, dst 2
    do_alloc(11);                 // R11: block 0 now free
    do_alloc(11);                 // R11: nothing else free -> fail

    // R10 equality then R9 firing
    do_erase(1);
    do_sweep(1, 10);              // R10: 1 == 0+1 -> no fire
    do_sweep(0, 9);               // R9: src 0 dst 1
    do_alloc(11);                 // R11 -> 0

    // mixed traffic against the model
    for (int k = 0; k < 300; k++) begin
      int r;
      int bads;
      r = int'($urandom_range(0, 9));
      bads = 0;
      for (int i = 0; i < N; i++) bads += int'(m_bad[i]);
      if (r < 4)                    do_alloc(2);
      else if (r < 7)               do_erase(int'($urandom_range(0, N - 1)));
      else if (r == 7 && bads < 3)  do_mark(int'($urandom_range(0, N - 1)));
      else                          do_sweep(int'($urandom_range(0, 3)), 9);
    end

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, 2, "outstanding results", exp_q.size(), 0);
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule